// File: doc/BRIEF.md
# Line and Frame Sync Generator

This block derives the horizontal and vertical drive pulses for an image sensor from one pixel clock. A pixel counter walks each line, and a line counter walks each frame. The horizontal pulse (`hd`) is high over the first part of every line. The vertical pulse (`vd`) spans a parameterised number of lines, starting on line 1.

Both edges of `vd` sit a fixed number of clocks after the rising edge of `hd`. Each `vd` edge therefore falls inside an `hd` high period, not on the line boundary.

The current pixel position and the line ordinal (counted from 1) are brought out, so neighbouring logic can schedule its own events against them. A one-clock `frame_start` strobe marks the first pixel of line 1. All outputs are registered. A synchronous reset parks the counters at the frame origin and keeps every pulse low until the first clock edge after reset is released.

Top module: `sync_timing_gen`

## Requirements
- R1: `pix_cnt` runs 0, 1, … `LINE_CLKS-1` and then returns to 0, advancing by one on every clock after the first edge following reset.
- R2: `hd` is 1 while `pix_cnt` is below `HD_HIGH` and 0 otherwise. It therefore rises together with `pix_cnt` = 0 and falls together with `pix_cnt` = `HD_HIGH`.
- R3: `line_no` stays within 1 … `FRAME_LINES`. It advances by one when `pix_cnt` wraps to 0, and after `FRAME_LINES` it goes back to 1.
- R4: `vd` rises on the clock where `line_no` = 1 and `pix_cnt` = `VD_DELAY`.
- R5: `vd` falls on the clock where `line_no` = `VD_LINES+1` and `pix_cnt` = `VD_DELAY`. Every change of `vd` happens while `hd` is 1.
- R6: `frame_start` is 1 for exactly the one clock where `line_no` = 1 and `pix_cnt` = 0, and it is 0 on every other clock.
- R7: While `rst` is sampled high, the next state is `pix_cnt` = 0, `line_no` = 1, and `hd`, `vd` and `frame_start` = 0.
- R8: On the first clock edge after `rst` is released, the outputs show `pix_cnt` = 0, `line_no` = 1, `hd` = 1 and `frame_start` = 1. This holds whether reset arrived at power-up or in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hd | output | 1 | Horizontal drive pulse |
| vd | output | 1 | Vertical drive pulse |
| frame_start | output | 1 | One-clock strobe at line 1, pixel 0 |
| line_no | output | $clog2(FRAME_LINES+1) | Current line ordinal, 1 … FRAME_LINES |
| pix_cnt | output | $clog2(LINE_CLKS) | Current pixel position in the line |

## Verification
A wrong pixel count shows up at once in `pix_cnt`. Within one line it also moves the falling edge of `hd` away from `HD_HIGH`.

A wrong line count stays hidden inside a line. It surfaces at the next wrap, where `line_no` steps wrongly. It also shows at the next frame boundary, where `frame_start` appears or goes missing and `vd` is misplaced by whole lines. Because of this, the bench compares every output on every clock across more than two full frames, using reduced sizes so that frame wraps come quickly.

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int LINE_CLKS   = 780,
  parameter int HD_HIGH     = 78,
  parameter int FRAME_LINES = 525,
  parameter int VD_LINES    = 9,
  parameter int VD_DELAY    = 20,
  localparam int PW = $clog2(LINE_CLKS),
  localparam int LW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hd,
  output logic          vd,
  output logic          frame_start,
  output logic [LW-1:0] line_no,
  output logic [PW-1:0] pix_cnt
);

  logic          run;
  logic [PW-1:0] pix_n;
  logic [LW-1:0] line_n;
  logic          vd_n;

  wire eol  = pix_cnt == PW'(LINE_CLKS - 1);
  wire eof  = line_no == LW'(FRAME_LINES);

  assign pix_n  = (!run || eol) ? '0 : pix_cnt + 1'b1;
  assign line_n = !run ? LW'(1) : !eol ? line_no : eof ? LW'(1) : line_no + 1'b1;

  // vd window: from (line 1, VD_DELAY) up to (line VD_LINES+1, VD_DELAY)
  wire vd_first = line_n == LW'(1) && pix_n >= PW'(VD_DELAY);
  wire vd_mid   = line_n >  LW'(1) && line_n <= LW'(VD_LINES);
  wire vd_last  = line_n == LW'(VD_LINES + 1) && pix_n < PW'(VD_DELAY);
  assign vd_n   = vd_first || vd_mid || vd_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run         <= 1'b0;
      pix_cnt     <= '0;
      line_no     <= LW'(1);
      hd          <= 1'b0;
      vd          <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      run         <= 1'b1;
      pix_cnt     <= pix_n;
      line_no     <= line_n;
      hd          <= pix_n < PW'(HD_HIGH);
      vd          <= vd_n;
      frame_start <= pix_n == '0 && line_n == LW'(1);
    end
  end

  AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    pix_cnt <= PW'(LINE_CLKS - 1)); // R1
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(run) && !$past(rst) && $past(pix_cnt) != PW'(LINE_CLKS - 1) |-> pix_cnt == $past(pix_cnt) + 1'b1); // R1
  AST_HD_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(hd) |-> pix_cnt == '0); // R2
  AST_HD_FALL_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(hd) |-> pix_cnt == PW'(HD_HIGH)); // R2
  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    line_no >= LW'(1) && line_no <= LW'(FRAME_LINES)); // R3
  AST_VD_RISE_POS: assert property (@(posedge clk) disable iff (rst)
    $rose(vd) |-> line_no == LW'(1) && pix_cnt == PW'(VD_DELAY)); // R4
  AST_VD_FALL_POS: assert property (@(posedge clk) disable iff (rst)
    $fell(vd) |-> line_no == LW'(VD_LINES + 1) && pix_cnt == PW'(VD_DELAY)); // R5
  AST_VD_EDGE_IN_HD: assert property (@(posedge clk) disable iff (rst)
    vd != $past(vd) |-> hd && $past(hd)); // R5
  AST_FRAME_START_POS: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_no == LW'(1) && pix_cnt == '0 && hd); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !hd && !vd && !frame_start && pix_cnt == '0 && line_no == LW'(1)); // R7
  AST_RELEASE_ORIGIN: assert property (@(posedge clk)
    $past(rst) && !rst |-> ##0 1'b1 ##1 (rst || (frame_start && hd && pix_cnt == '0))); // R8

endmodule

// File: tb/tb_sync_timing_gen.sv
module tb_sync_timing_gen;
  localparam int L = 100, H = 78, F = 12, VL = 3, OFF = 10;
  localparam int PW = $clog2(L), LW = $clog2(F + 1);

  logic clk = 0, rst = 1;
  logic hd, vd, frame_start;
  logic [LW-1:0] line_no;
  logic [PW-1:0] pix_cnt;
  int checks = 0, errors = 0, cur = -1;

  always #2 clk = ~clk;

  sync_timing_gen #(.LINE_CLKS(L), .HD_HIGH(H), .FRAME_LINES(F), .VD_LINES(VL), .VD_DELAY(OFF)) dut (
    .clk(clk), .rst(rst), .hd(hd), .vd(vd), .frame_start(frame_start),
    .line_no(line_no), .pix_cnt(pix_cnt));

  // columns: t, pix, line, hd, vd, frame_start
  localparam int VEC [12][6] = '{
    '{0,    0,  1,  1, 0, 1},   // R6 R8 origin
    '{9,    9,  1,  1, 0, 0},   // R4 just before rise
    '{10,   10, 1,  1, 1, 0},   // R4 rise
    '{77,   77, 1,  1, 1, 0},   // R2 last high
    '{78,   78, 1,  0, 1, 0},   // R2 fall
    '{99,   99, 1,  0, 1, 0},   // R1 end of line
    '{100,  0,  2,  1, 1, 0},   // R1 R3 wrap
    '{309,  9,  4,  1, 1, 0},   // R5 before fall
    '{310,  10, 4,  1, 0, 0},   // R5 fall
    '{1199, 99, 12, 0, 0, 0},   // R3 last pixel of frame
    '{1200, 0,  1,  1, 0, 1},   // R3 R6 frame wrap
    '{1210, 10, 1,  1, 1, 0}    // R4 second frame
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", req, cur, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cur++;
  endtask

  task automatic check_model(int t);
    int p = t % L, l = (t / L) % F + 1, g = (l - 1) * L + p;
    check("R1 pix", int'(pix_cnt), p);
    check("R3 line", int'(line_no), l);
    check("R2 hd", int'(hd), int'(p < H));
    check("R4/R5 vd", int'(vd), int'(g >= OFF && g < VL * L + OFF));
    check("R6 frame_start", int'(frame_start), int'(p == 0 && l == 1));
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check("R7 pix", int'(pix_cnt), 0);
    check("R7 line", int'(line_no), 1);
    check("R7 hd", int'(hd), 0);
    check("R7 vd", int'(vd), 0);
    check("R7 frame_start", int'(frame_start), 0);
    rst = 0;
    for (int i = 0; i < 12; i++) begin
      while (cur < VEC[i][0]) step();
      check("R1 pix", int'(pix_cnt), VEC[i][1]);
      check("R3 line", int'(line_no), VEC[i][2]);
      check("R2 hd", int'(hd), VEC[i][3]);
      check("R4/R5 vd", int'(vd), VEC[i][4]);
      check("R6 frame_start", int'(frame_start), VEC[i][5]);
    end
    // R8 mid-frame reset while vd is high
    rst = 1;
    step();
    check("R7 mid pix", int'(pix_cnt), 0);
    check("R7 mid line", int'(line_no), 1);
    check("R7 mid vd", int'(vd), 0);
    check("R7 mid hd", int'(hd), 0);
    step();
    rst = 0;
    cur = -1;
    step();
    check("R8 pix", int'(pix_cnt), 0);
    check("R8 hd", int'(hd), 1);
    check("R8 frame_start", int'(frame_start), 1);
    // full scan over more than two frames
    for (int n = 0; n < 2 * L * F + 250; n++) begin
      check_model(cur);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule